// File: doc/BRIEF.md
# PCI Target Address and Command Decoder

This block sits behind the PCI target state machine of a device that exposes three internal regions to the bus: a control/status register space, a DRAM window and an SRAM window. Each region has a base address register (BAR). For every address phase the block checks the bus command and the address against the BARs. One cycle later it reports whether the transaction is claimed, which region it targets, the offset inside that region, whether it is a read or a write, and how many dwords a read should fetch.

The size of each memory window is held as a mask. A set mask bit marks an address bit that must equal the BAR. A boot-mode input is captured once, when chip reset is released, and the mask source follows from it:

- **Strap mode** (boot input low): the DRAM and SRAM masks come from two strap inputs. The embedded processor is kept in reset.
- **Boot mode** (boot input high): the processor runs. Its firmware writes the masks through a small register port.

In both modes the BARs, the masks and the cache line size are read and written through that same register port. A BAR reads back with its masked low bits cleared, so software sees the window size by writing all ones to a BAR.

The extended memory commands are folded onto the plain read and write classes. Only SRAM reads issued with the multiple-line or line command fetch a cache line. Reserved commands, I/O commands, locked cycles and dual address cycles are never claimed.

Top module: `pci_tgt_decode`

## Requirements
- R1: The boot mode is taken from `boot_sel_i` at the first rising clock edge with `rst_n` high after a reset. Changes of `boot_sel_i` after that edge have no effect until the next reset.
- R2: `cpu_rst_o` is 1 while `rst_n` is low. From the capture edge onward it is 0 in boot mode and stays 1 in strap mode.
- R3: In strap mode the effective DRAM mask is all ones above bit `DRAM_MIN_LOG2 + strap_dwin_i`, and the SRAM mask is all ones above bit `SRAM_MIN_LOG2 + strap_swin_i`. Writes to the mask registers (select 3 = DRAM mask, 4 = SRAM mask) are ignored, and reading a mask returns the effective value.
- R4: In boot mode the effective masks are the mask registers. They reset to the minimum window (strap value 0) and take `reg_wdata_i` when written.
- R5: Register port selects are: 0 = CSR BAR, 1 = DRAM BAR, 2 = SRAM BAR, 5 = cache line size. A BAR write stores the data ANDed with the effective mask of its region, and a BAR read returns the stored value ANDed with that mask. The CSR mask is fixed at all ones above bit `CSR_LOG2`.
- R6: A region is hit when the address ANDed with its mask equals its BAR ANDed with the mask. If several regions hit, the priority is CSR, then DRAM, then SRAM. `region_o` codes are 1 = CSR, 2 = DRAM, 3 = SRAM, 0 = none.
- R7: `offset_o` is the address ANDed with the inverse of the hit region's mask.
- R8: Only commands 0x6 and 0xC and 0xE (read class, `is_write_o` = 0) and 0x7 and 0xF (write class, `is_write_o` = 1) are claimed. All other codes are never claimed, including 0xD and the I/O commands 0x2 and 0x3.
- R9: An address phase with `ap_lock_i` high is never claimed.
- R10: A claimed 0xC or 0xE read that hits SRAM reports `burst_o` equal to the cache line size register, or 1 if that register is 0. Every other claimed transaction reports 1.
- R11: The outputs update at the clock edge that samples `ap_valid_i`. When `ap_valid_i` is low, or the phase is not claimed, `hit_o`, `region_o`, `offset_o`, `is_write_o` and `burst_o` are all 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| boot_sel_i | input | 1 | Boot-mode input, captured after reset |
| strap_dwin_i | input | STRAP_W | DRAM window size strap |
| strap_swin_i | input | STRAP_W | SRAM window size strap |
| reg_wr_i | input | 1 | Register port write strobe |
| reg_sel_i | input | 3 | Register port select |
| reg_wdata_i | input | AW | Register port write data |
| reg_rdata_o | output | AW | Register port read data (combinational on select) |
| ap_valid_i | input | 1 | Address phase strobe |
| ap_addr_i | input | AW | Address phase address |
| ap_cmd_i | input | 4 | Address phase command code |
| ap_lock_i | input | 1 | Address phase belongs to a locked cycle |
| hit_o | output | 1 | Transaction claimed |
| region_o | output | 2 | Region code |
| offset_o | output | AW | Offset inside the region |
| is_write_o | output | 1 | Write class |
| burst_o | output | CLS_W | Read burst length in dwords |
| cpu_rst_o | output | 1 | Embedded processor reset |

## Verification
A wrong boot-mode latch shows up in two places at once. `cpu_rst_o` takes the wrong level one edge after reset is released. The mask readback also returns strap-derived values where programmed values are expected, or the other way round. A wrong mask or BAR shows up as a wrong `reg_rdata_o` as soon as the register is selected, and as a wrong hit, region or offset in the address phase one cycle later. A wrong command classification or burst choice shows up on `is_write_o` or `burst_o` in the single cycle after the strobe. Because the outputs are cleared between phases, stale state cannot hide behind an earlier result.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_CSR  = 2'd1,
      RGN_DRAM = 2'd2,
      RGN_SRAM = 2'd3
   } rgn_e;

   typedef enum logic [2:0] {
      SEL_CSR_BAR   = 3'd0,
      SEL_DRAM_BAR  = 3'd1,
      SEL_SRAM_BAR  = 3'd2,
      SEL_DRAM_MASK = 3'd3,
      SEL_SRAM_MASK = 3'd4,
      SEL_CLS       = 3'd5
   } rsel_e;

   localparam logic [3:0] CMD_MEM_RD    = 4'h6;
   localparam logic [3:0] CMD_MEM_WR    = 4'h7;
   localparam logic [3:0] CMD_MEM_RD_ML = 4'hC;
   localparam logic [3:0] CMD_MEM_RD_LN = 4'hE;
   localparam logic [3:0] CMD_MEM_WR_IV = 4'hF;

   localparam int NUM_RGN = 3;

   typedef struct packed {
      logic claim;
      logic is_wr;
      logic ext_rd;
   } cmd_info_t;

endpackage

// File: rtl/pci_tgt_mode.sv
module pci_tgt_mode (
   input  logic clk,
   input  logic rst_n,
   input  logic boot_sel_i,
   output logic boot_mode_o,
   output logic cpu_rst_o
);

   logic captured_q;
   logic boot_q;
   logic cpu_rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         captured_q <= 1'b0;
         boot_q     <= 1'b0;
         cpu_rst_q  <= 1'b1;
      end else if (!captured_q) begin
         captured_q <= 1'b1;
         boot_q     <= boot_sel_i;
         cpu_rst_q  <= ~boot_sel_i;
      end
   end

   assign boot_mode_o = boot_q;
   assign cpu_rst_o   = cpu_rst_q;

endmodule

// File: rtl/pci_tgt_regs.sv
module pci_tgt_regs
   import pci_tgt_pkg::*;
#(
   parameter int AW            = 32,
   parameter int STRAP_W       = 2,
   parameter int CSR_LOG2      = 20,
   parameter int DRAM_MIN_LOG2 = 24,
   parameter int SRAM_MIN_LOG2 = 20,
   parameter int CLS_W         = 8,
   parameter int CLS_RESET     = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        boot_mode_i,
   input  logic [STRAP_W-1:0]          strap_dwin_i,
   input  logic [STRAP_W-1:0]          strap_swin_i,
   input  logic                        reg_wr_i,
   input  logic [2:0]                  reg_sel_i,
   input  logic [AW-1:0]               reg_wdata_i,
   output logic [AW-1:0]               reg_rdata_o,
   output logic [NUM_RGN-1:0][AW-1:0]  bar_o,
   output logic [NUM_RGN-1:0][AW-1:0]  mask_o,
   output logic [CLS_W-1:0]            cls_o
);

   localparam int NUM_MEM = 2;

   function automatic logic [AW-1:0] win_mask(input int unsigned lg);
      return {AW{1'b1}} << lg;
   endfunction

   logic [NUM_RGN-1:0][AW-1:0] bar_q;
   logic [NUM_MEM-1:0][AW-1:0] mreg_q;
   logic [NUM_MEM-1:0][AW-1:0] strap_mask;
   logic [NUM_MEM-1:0][AW-1:0] reset_mask;
   logic [CLS_W-1:0]           cls_q;

   assign strap_mask[0] = win_mask(DRAM_MIN_LOG2 + int'(strap_dwin_i));
   assign strap_mask[1] = win_mask(SRAM_MIN_LOG2 + int'(strap_swin_i));
   assign reset_mask[0] = win_mask(DRAM_MIN_LOG2);
   assign reset_mask[1] = win_mask(SRAM_MIN_LOG2);

   assign mask_o[0] = win_mask(CSR_LOG2);

   for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem_mask
      logic sel_hit;
      assign sel_hit     = (reg_sel_i == (SEL_DRAM_MASK + 3'(m)));
      assign mask_o[m+1] = boot_mode_i ? mreg_q[m] : strap_mask[m];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mreg_q[m] <= reset_mask[m];
         end else if (reg_wr_i && sel_hit && boot_mode_i) begin
            mreg_q[m] <= reg_wdata_i;
         end
      end
   end

   for (genvar r = 0; r < NUM_RGN; r++) begin : g_bar
      logic sel_hit;
      assign sel_hit  = (reg_sel_i == (SEL_CSR_BAR + 3'(r)));
      assign bar_o[r] = bar_q[r] & mask_o[r];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bar_q[r] <= '0;
         end else if (reg_wr_i && sel_hit) begin
            bar_q[r] <= reg_wdata_i & mask_o[r];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cls_q <= CLS_W'(CLS_RESET);
      end else if (reg_wr_i && reg_sel_i == SEL_CLS) begin
         cls_q <= reg_wdata_i[CLS_W-1:0];
      end
   end

   assign cls_o = cls_q;

   always_comb begin
      reg_rdata_o = '0;
      case (reg_sel_i)
         SEL_CSR_BAR:   reg_rdata_o = bar_o[0];
         SEL_DRAM_BAR:  reg_rdata_o = bar_o[1];
         SEL_SRAM_BAR:  reg_rdata_o = bar_o[2];
         SEL_DRAM_MASK: reg_rdata_o = mask_o[1];
         SEL_SRAM_MASK: reg_rdata_o = mask_o[2];
         SEL_CLS:       reg_rdata_o = {{(AW-CLS_W){1'b0}}, cls_q};
         default:       reg_rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/pci_tgt_match.sv
module pci_tgt_match #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] addr_i,
   input  logic [AW-1:0] bar_i,
   input  logic [AW-1:0] mask_i,
   output logic          hit_o,
   output logic [AW-1:0] offset_o
);

   assign hit_o    = ((addr_i ^ bar_i) & mask_i) == '0;
   assign offset_o = addr_i & ~mask_i;

endmodule

// File: rtl/pci_tgt_cmd.sv
module pci_tgt_cmd
   import pci_tgt_pkg::*;
(
   input  logic [3:0] cmd_i,
   input  logic       lock_i,
   output cmd_info_t  info_o
);

   logic known;

   always_comb begin
      known         = 1'b0;
      info_o.is_wr  = 1'b0;
      info_o.ext_rd = 1'b0;
      case (cmd_i)
         CMD_MEM_RD:    known = 1'b1;
         CMD_MEM_RD_ML,
         CMD_MEM_RD_LN: begin
            known         = 1'b1;
            info_o.ext_rd = 1'b1;
         end
         CMD_MEM_WR,
         CMD_MEM_WR_IV: begin
            known        = 1'b1;
            info_o.is_wr = 1'b1;
         end
         default:       known = 1'b0;
      endcase
      info_o.claim = known & ~lock_i;
   end

endmodule

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
   import pci_tgt_pkg::*;
#(
   parameter int AW            = 32,
   parameter int STRAP_W       = 2,
   parameter int CSR_LOG2      = 20,
   parameter int DRAM_MIN_LOG2 = 24,
   parameter int SRAM_MIN_LOG2 = 20,
   parameter int CLS_W         = 8,
   parameter int CLS_RESET     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               boot_sel_i,
   input  logic [STRAP_W-1:0] strap_dwin_i,
   input  logic [STRAP_W-1:0] strap_swin_i,
   input  logic               reg_wr_i,
   input  logic [2:0]         reg_sel_i,
   input  logic [AW-1:0]      reg_wdata_i,
   output logic [AW-1:0]      reg_rdata_o,
   input  logic               ap_valid_i,
   input  logic [AW-1:0]      ap_addr_i,
   input  logic [3:0]         ap_cmd_i,
   input  logic               ap_lock_i,
   output logic               hit_o,
   output logic [1:0]         region_o,
   output logic [AW-1:0]      offset_o,
   output logic               is_write_o,
   output logic [CLS_W-1:0]   burst_o,
   output logic               cpu_rst_o
);

   localparam int MAX_STRAP = (1 << STRAP_W) - 1;

   initial begin
      if (AW < 16 || AW > 64)
         $error("AW out of range");
      if (DRAM_MIN_LOG2 + MAX_STRAP >= AW)
         $error("DRAM strap range exceeds address width");
      if (SRAM_MIN_LOG2 + MAX_STRAP >= AW)
         $error("SRAM strap range exceeds address width");
      if (CSR_LOG2 < 4 || CSR_LOG2 >= AW)
         $error("CSR window out of range");
      if (CLS_W < 1 || CLS_W > AW || CLS_RESET >= (1 << CLS_W))
         $error("cache line size width or reset value invalid");
   end

   logic                       boot_mode;
   logic [NUM_RGN-1:0][AW-1:0] bar;
   logic [NUM_RGN-1:0][AW-1:0] mask;
   logic [CLS_W-1:0]           cls;
   cmd_info_t                  info;
   logic [NUM_RGN-1:0]         rgn_hit;
   logic [NUM_RGN-1:0][AW-1:0] rgn_off;

   pci_tgt_mode u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .boot_sel_i  (boot_sel_i),
      .boot_mode_o (boot_mode),
      .cpu_rst_o   (cpu_rst_o)
   );

   pci_tgt_regs #(
      .AW            (AW),
      .STRAP_W       (STRAP_W),
      .CSR_LOG2      (CSR_LOG2),
      .DRAM_MIN_LOG2 (DRAM_MIN_LOG2),
      .SRAM_MIN_LOG2 (SRAM_MIN_LOG2),
      .CLS_W         (CLS_W),
      .CLS_RESET     (CLS_RESET)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .boot_mode_i  (boot_mode),
      .strap_dwin_i (strap_dwin_i),
      .strap_swin_i (strap_swin_i),
      .reg_wr_i     (reg_wr_i),
      .reg_sel_i    (reg_sel_i),
      .reg_wdata_i  (reg_wdata_i),
      .reg_rdata_o  (reg_rdata_o),
      .bar_o        (bar),
      .mask_o       (mask),
      .cls_o        (cls)
   );

   pci_tgt_cmd u_cmd (
      .cmd_i  (ap_cmd_i),
      .lock_i (ap_lock_i),
      .info_o (info)
   );

   for (genvar r = 0; r < NUM_RGN; r++) begin : g_match
      pci_tgt_match #(.AW(AW)) u_match (
         .addr_i   (ap_addr_i),
         .bar_i    (bar[r]),
         .mask_i   (mask[r]),
         .hit_o    (rgn_hit[r]),
         .offset_o (rgn_off[r])
      );
   end

   rgn_e             sel_rgn;
   logic [AW-1:0]    sel_off;
   logic [CLS_W-1:0] sel_burst;
   logic             claim_now;

   always_comb begin
      sel_rgn = RGN_NONE;
      sel_off = '0;
      if (rgn_hit[0]) begin
         sel_rgn = RGN_CSR;
         sel_off = rgn_off[0];
      end else if (rgn_hit[1]) begin
         sel_rgn = RGN_DRAM;
         sel_off = rgn_off[1];
      end else if (rgn_hit[2]) begin
         sel_rgn = RGN_SRAM;
         sel_off = rgn_off[2];
      end
   end

   always_comb begin
      sel_burst = CLS_W'(1);
      if (info.ext_rd && sel_rgn == RGN_SRAM && cls != '0)
         sel_burst = cls;
   end

   assign claim_now = ap_valid_i && info.claim && (sel_rgn != RGN_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_o      <= 1'b0;
         region_o   <= RGN_NONE;
         offset_o   <= '0;
         is_write_o <= 1'b0;
         burst_o    <= '0;
      end else if (claim_now) begin
         hit_o      <= 1'b1;
         region_o   <= sel_rgn;
         offset_o   <= sel_off;
         is_write_o <= info.is_wr;
         burst_o    <= sel_burst;
      end else begin
         hit_o      <= 1'b0;
         region_o   <= RGN_NONE;
         offset_o   <= '0;
         is_write_o <= 1'b0;
         burst_o    <= '0;
      end
   end

endmodule

// File: rtl/pci_tgt_decode_chk.sv
module pci_tgt_decode_chk #(
   parameter int CLS_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ap_valid_i,
   input logic [3:0]       ap_cmd_i,
   input logic             ap_lock_i,
   input logic             hit_o,
   input logic [1:0]       region_o,
   input logic             is_write_o,
   input logic [CLS_W-1:0] burst_o,
   input logic             cpu_rst_o
);

   // R2
   cpu_rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rst_o |=> !cpu_rst_o);

   // R11
   idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ap_valid_i |=> (!hit_o && region_o == 2'd0 && burst_o == '0));

   // R9
   lock_not_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_valid_i && ap_lock_i) |=> !hit_o);

   // R8
   reserved_not_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_valid_i && (ap_cmd_i == 4'hD || ap_cmd_i == 4'h2 || ap_cmd_i == 4'h3)) |=> !hit_o);

   // R6
   hit_has_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> region_o != 2'd0);

   // R10
   write_burst_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o && is_write_o) |-> burst_o == CLS_W'(1));

   // R10
   claimed_burst_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> burst_o != '0);

endmodule

bind pci_tgt_decode pci_tgt_decode_chk #(.CLS_W(CLS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ap_valid_i (ap_valid_i),
   .ap_cmd_i   (ap_cmd_i),
   .ap_lock_i  (ap_lock_i),
   .hit_o      (hit_o),
   .region_o   (region_o),
   .is_write_o (is_write_o),
   .burst_o    (burst_o),
   .cpu_rst_o  (cpu_rst_o)
);

// File: tb/test_pci_tgt_decode.sv
`timescale 1ns/1ps
module test_pci_tgt_decode;

   localparam int AW = 32;
   localparam int SW = 2;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          boot_sel = 1'b0;
   logic [SW-1:0] strap_dwin = 2'd1;
   logic [SW-1:0] strap_swin = 2'd2;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_sel = 3'd0;
   logic [AW-1:0] reg_wdata = '0;
   logic [AW-1:0] reg_rdata;
   logic          ap_valid = 1'b0;
   logic [AW-1:0] ap_addr = '0;
   logic [3:0]    ap_cmd = 4'h0;
   logic          ap_lock = 1'b0;
   logic          hit;
   logic [1:0]    region;
   logic [AW-1:0] offset;
   logic          is_write;
   logic [CW-1:0] burst;
   logic          cpu_rst;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pci_tgt_decode i_pci_tgt_decode (
      .clk          (clk),
      .rst_n        (rst_n),
      .boot_sel_i   (boot_sel),
      .strap_dwin_i (strap_dwin),
      .strap_swin_i (strap_swin),
      .reg_wr_i     (reg_wr),
      .reg_sel_i    (reg_sel),
      .reg_wdata_i  (reg_wdata),
      .reg_rdata_o  (reg_rdata),
      .ap_valid_i   (ap_valid),
      .ap_addr_i    (ap_addr),
      .ap_cmd_i     (ap_cmd),
      .ap_lock_i    (ap_lock),
      .hit_o        (hit),
      .region_o     (region),
      .offset_o     (offset),
      .is_write_o   (is_write),
      .burst_o      (burst),
      .cpu_rst_o    (cpu_rst)
   );

   typedef struct packed {
      logic [3:0]  cmd;
      logic [31:0] addr;
      logic        hit;
      logic [1:0]  rgn;
      logic [31:0] off;
      logic        wr;
      logic [7:0]  bst;
   } vec_t;

   // Strap mode: CSR BAR 0x4000_0000 (1 MB), DRAM BAR 0x8000_0000 (32 MB),
   // SRAM BAR 0x2000_0000 (4 MB), cache line size 16.
   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{4'h6, 32'h4000_1234, 1'b1, 2'd1, 32'h0000_1234, 1'b0, 8'd1},
      '{4'h7, 32'h8123_4568, 1'b1, 2'd2, 32'h0123_4568, 1'b1, 8'd1},
      '{4'hC, 32'h2012_3450, 1'b1, 2'd3, 32'h0012_3450, 1'b0, 8'd16},
      '{4'hE, 32'h2000_0010, 1'b1, 2'd3, 32'h0000_0010, 1'b0, 8'd16},
      '{4'h6, 32'h2000_0020, 1'b1, 2'd3, 32'h0000_0020, 1'b0, 8'd1},
      '{4'hC, 32'h8000_0040, 1'b1, 2'd2, 32'h0000_0040, 1'b0, 8'd1},
      '{4'hF, 32'h2000_0008, 1'b1, 2'd3, 32'h0000_0008, 1'b1, 8'd1},
      '{4'hD, 32'h2000_0000, 1'b0, 2'd0, 32'h0000_0000, 1'b0, 8'd0},
      '{4'h2, 32'h4000_0000, 1'b0, 2'd0, 32'h0000_0000, 1'b0, 8'd0},
      '{4'h6, 32'h8200_0000, 1'b0, 2'd0, 32'h0000_0000, 1'b0, 8'd0},
      '{4'h6, 32'h2040_0000, 1'b0, 2'd0, 32'h0000_0000, 1'b0, 8'd0},
      '{4'hE, 32'h4000_0100, 1'b1, 2'd1, 32'h0000_0100, 1'b0, 8'd1}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_sel   = sel;
      reg_wdata = data;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] sel, input logic [31:0] exp);
      reg_sel = sel;
      #1;
      chk(req, "register readback", reg_rdata, exp);
   endtask

   task automatic phase(input logic [3:0] cmd, input logic [31:0] addr, input logic lock);
      @(negedge clk);
      ap_valid = 1'b1;
      ap_cmd   = cmd;
      ap_addr  = addr;
      ap_lock  = lock;
      @(negedge clk);
      ap_valid = 1'b0;
      ap_lock  = 1'b0;
   endtask

   task automatic out_chk(input string req, input logic h, input logic [1:0] r,
                          input logic [31:0] o, input logic w, input logic [7:0] b);
      chk(req, "hit", {31'd0, hit}, {31'd0, h});
      chk(req, "region", {30'd0, region}, {30'd0, r});
      chk(req, "offset", offset, o);
      chk(req, "is_write", {31'd0, is_write}, {31'd0, w});
      chk(req, "burst", {24'd0, burst}, {24'd0, b});
   endtask

   task automatic do_reset(input logic boot);
      @(negedge clk);
      rst_n = 1'b0;
      boot_sel = boot;
      repeat (3) @(negedge clk);
      chk("R2", "cpu reset during reset", {31'd0, cpu_rst}, 32'd1);
      chk("R11", "hit during reset", {31'd0, hit}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // strap mode
      do_reset(1'b0);
      chk("R2", "cpu reset held in strap mode", {31'd0, cpu_rst}, 32'd1);
      boot_sel = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "late boot input ignored", {31'd0, cpu_rst}, 32'd1);
      rd_chk("R3", 3'd3, 32'hFE00_0000);
      rd_chk("R3", 3'd4, 32'hFFC0_0000);
      wr_reg(3'd3, 32'hFFF0_0000);
      rd_chk("R3", 3'd3, 32'hFE00_0000);
      rd_chk("R1", 3'd3, 32'hFE00_0000);
      wr_reg(3'd1, 32'hFFFF_FFFF);
      rd_chk("R5", 3'd1, 32'hFE00_0000);
      wr_reg(3'd0, 32'h4000_0ABC);
      rd_chk("R5", 3'd0, 32'h4000_0000);
      wr_reg(3'd1, 32'h8000_0000);
      wr_reg(3'd2, 32'h2000_0000);
      wr_reg(3'd5, 32'd16);
      rd_chk("R5", 3'd5, 32'd16);

      // vector table: R6 R7 R8 R10
      for (int i = 0; i < NV; i++) begin
         phase(VEC[i].cmd, VEC[i].addr, 1'b0);
         out_chk($sformatf("R6/R7/R8/R10 vec%0d", i), VEC[i].hit, VEC[i].rgn,
                 VEC[i].off, VEC[i].wr, VEC[i].bst);
      end

      // R9 locked cycle
      phase(4'h6, 32'h4000_0010, 1'b1);
      out_chk("R9", 1'b0, 2'd0, 32'd0, 1'b0, 8'd0);

      // R11 outputs cleared when no strobe follows a hit
      phase(4'h6, 32'h4000_0010, 1'b0);
      chk("R11", "hit after strobe", {31'd0, hit}, 32'd1);
      @(negedge clk);
      out_chk("R11", 1'b0, 2'd0, 32'd0, 1'b0, 8'd0);

      // R10 cache line size zero
      wr_reg(3'd5, 32'd0);
      phase(4'hC, 32'h2000_0100, 1'b0);
      out_chk("R10", 1'b1, 2'd3, 32'h0000_0100, 1'b0, 8'd1);

      // boot mode
      do_reset(1'b1);
      chk("R2", "cpu released in boot mode", {31'd0, cpu_rst}, 32'd0);
      boot_sel = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1", "late boot input ignored", {31'd0, cpu_rst}, 32'd0);
      rd_chk("R4", 3'd3, 32'hFF00_0000);
      rd_chk("R4", 3'd4, 32'hFFF0_0000);
      rd_chk("R5", 3'd5, 32'd8);
      wr_reg(3'd3, 32'hFFF0_0000);
      rd_chk("R4", 3'd3, 32'hFFF0_0000);
      wr_reg(3'd1, 32'h8000_0000);
      wr_reg(3'd2, 32'h8000_0000);
      phase(4'h6, 32'h8000_0010, 1'b0);
      out_chk("R6 priority", 1'b1, 2'd2, 32'h0000_0010, 1'b0, 8'd1);
      phase(4'h6, 32'h8010_0000, 1'b0);
      out_chk("R4 window", 1'b0, 2'd0, 32'd0, 1'b0, 8'd0);
      phase(4'hE, 32'h0000_0044, 1'b0);
      out_chk("R6 csr at zero", 1'b1, 2'd1, 32'h0000_0044, 1'b0, 8'd1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule